// File: doc/BRIEF.md
# Byte-oriented register ALU

This unit carries out the byte-wide file-register operations of a small 8-bit controller core. Each cycle it receives the opcode bits of an already-fetched instruction word, the byte read from the addressed file register, the accumulator (working register) and the current status flags. From these it forms an 8-bit result at once and raises one of two write strobes: one for the accumulator, one for the file register. Which strobe rises depends on the destination bit of the instruction, or is fixed by the operation itself.

Each operation changes only its own subset of the five status flags. The others pass through unchanged. The new flag word and the 16-bit product of a multiply are captured on the next rising clock edge. The enclosing core is expected to feed the captured flags back as the next flag input. Address and bank generation, the register file, conditional skips and instruction fetch sit outside this block.

Top module: `byte_reg_alu`

## Requirements
- R1: The port `ins_hi` carries instruction bits 15..9. Bits 15..10 pick the operation. For operations that take a destination bit (bit 9, `ins_hi[0]`), 0 raises `wr_w` only and 1 raises `wr_f` only. Clear, set-all-ones, negate and move-accumulator-to-file always raise `wr_f`. The two strobes are never high together.
- R2: Flags use the layout bit0 C, bit1 DC, bit2 Z, bit3 OV, bit4 N. The add-type operations update all five flags from the 8-bit sum. These are add (001001), add with carry (001000), increment (001010), decrement (000001) and negate (0110110 in bits 15..9). C is the carry out of bit 7, DC the carry out of bit 3, OV the signed overflow, N bit 7 and Z set for a zero result.
- R3: The subtract operations update all five flags, with C = NOT borrow and DC = NOT borrow out of bit 3. These are f minus accumulator (010111), f minus accumulator minus borrow (010110) and accumulator minus f minus borrow (010101).
- R4: AND (000101), inclusive OR (000100), exclusive OR (000110), complement (000111) and move f (010100) update only Z and N.
- R5: Rotate right and rotate left through carry (001100, 001101) feed the old C in and move the bit shifted out into C, updating C, Z and N. Rotates without carry (010000, 010001) update only Z and N.
- R6: Swap nibbles (001110), set all ones (0110100) and move accumulator to file (0110111) leave every flag unchanged. Clear (0110101) gives zero and sets Z, leaving every other flag unchanged.
- R7: Multiply (0000001) captures accumulator times f into `prod_hi`/`prod_lo` on the next edge. It raises no write strobe and leaves the flags unchanged. No other operation changes the product.
- R8: An opcode not listed here raises no write strobe, and the captured flags equal the flag input.
- R9: While `rst_n` is low, `flags_q`, `prod_hi` and `prod_lo` are zero.
- R10: `res`, `wr_w` and `wr_f` follow the inputs in the same cycle. `flags_q` and the product change only at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_hi | input | 7 | Instruction bits 15..9 (operation code and destination bit) |
| fop | input | 8 | Byte read from the addressed file register |
| wop | input | 8 | Accumulator value |
| flags_in | input | 5 | Current flags {N, OV, Z, DC, C} |
| res | output | 8 | Operation result |
| wr_w | output | 1 | Write result to accumulator |
| wr_f | output | 1 | Write result to file register |
| flags_q | output | 5 | Captured updated flags |
| prod_hi | output | 8 | Captured product, high byte |
| prod_lo | output | 8 | Captured product, low byte |

## Verification
Each operation is driven with operands that sit at an edge of its arithmetic. These include a low-nibble carry without a byte carry, a positive-plus-positive sum that overflows into the sign bit, a wrap to zero, and subtracts that do and do not borrow. Together they separate the C, DC, OV, Z and N rules from one another. The logic, rotate and swap cases start from an input flag word with unrelated bits set, so a flag that leaks into an update shows up against the bits that should pass through. Multiply is run with all-ones operands and followed by a non-multiply operation to show that the product holds. A check taken before the clock edge tells the same-cycle result apart from the registered flags.

// File: rtl/bya_pkg.sv
`timescale 1ns/1ps
package bya_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned HALF_W  = DATA_W / 2;
  localparam int unsigned PROD_W  = 2 * DATA_W;
  localparam int unsigned OPSEL_W = 7;
  localparam int unsigned FLAG_W  = 5;

  // flag bit positions
  localparam int unsigned FL_C  = 0;
  localparam int unsigned FL_DC = 1;
  localparam int unsigned FL_Z  = 2;
  localparam int unsigned FL_OV = 3;
  localparam int unsigned FL_N  = 4;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [FLAG_W-1:0] flags_t;

  typedef enum logic [4:0] {
    OP_NONE, OP_ADD, OP_ADDC, OP_SUBWF, OP_SUBWFB, OP_SUBFWB,
    OP_INC, OP_DEC, OP_NEG, OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV,
    OP_RRC, OP_RLC, OP_RRN, OP_RLN, OP_SWAP, OP_SET, OP_CLR, OP_MOVW, OP_MUL
  } alu_op_e;

  // which flags each class of operation may touch
  localparam flags_t MASK_ALL  = 5'b11111;
  localparam flags_t MASK_ZN   = 5'b10100;
  localparam flags_t MASK_CZN  = 5'b10101;
  localparam flags_t MASK_Z    = 5'b00100;
  localparam flags_t MASK_NONE = 5'b00000;

  typedef struct packed {
    logic  c;
    logic  dc;
    logic  ov;
    byte_t sum;
  } add_t;

  // full adder over the byte with carry from the low half and signed overflow
  function automatic add_t add_bytes(byte_t a, byte_t b, logic ci);
    logic [DATA_W:0] full;
    logic [HALF_W:0] low;
    add_t r;
    full  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
    low   = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, ci};
    r.sum = full[DATA_W-1:0];
    r.c   = full[DATA_W];
    r.dc  = low[HALF_W];
    r.ov  = (a[DATA_W-1] == b[DATA_W-1]) && (r.sum[DATA_W-1] != a[DATA_W-1]);
    return r;
  endfunction

  function automatic byte_t swap_halves(byte_t v);
    return {v[HALF_W-1:0], v[DATA_W-1:HALF_W]};
  endfunction
endpackage

// File: rtl/bya_decode.sv
`timescale 1ns/1ps
module bya_decode
  import bya_pkg::*;
(
  input  logic [OPSEL_W-1:0] sel_i,
  output alu_op_e            op_o,
  output flags_t             mask_o,
  output logic               to_file_o,
  output logic               has_dbit_o,
  output logic               known_o
);
  logic [OPSEL_W-2:0] major;
  logic               low_bit;

  assign major   = sel_i[OPSEL_W-1:1];
  assign low_bit = sel_i[0];

  always_comb begin
    op_o       = OP_NONE;
    mask_o     = MASK_NONE;
    has_dbit_o = 1'b1;
    to_file_o  = low_bit;
    case (major)
      6'b001001: begin op_o = OP_ADD;    mask_o = MASK_ALL; end
      6'b001000: begin op_o = OP_ADDC;   mask_o = MASK_ALL; end
      6'b001010: begin op_o = OP_INC;    mask_o = MASK_ALL; end
      6'b000001: begin op_o = OP_DEC;    mask_o = MASK_ALL; end
      6'b010111: begin op_o = OP_SUBWF;  mask_o = MASK_ALL; end
      6'b010110: begin op_o = OP_SUBWFB; mask_o = MASK_ALL; end
      6'b010101: begin op_o = OP_SUBFWB; mask_o = MASK_ALL; end
      6'b000101: begin op_o = OP_AND;    mask_o = MASK_ZN;  end
      6'b000100: begin op_o = OP_IOR;    mask_o = MASK_ZN;  end
      6'b000110: begin op_o = OP_XOR;    mask_o = MASK_ZN;  end
      6'b000111: begin op_o = OP_COM;    mask_o = MASK_ZN;  end
      6'b010100: begin op_o = OP_MOV;    mask_o = MASK_ZN;  end
      6'b001100: begin op_o = OP_RRC;    mask_o = MASK_CZN; end
      6'b001101: begin op_o = OP_RLC;    mask_o = MASK_CZN; end
      6'b010000: begin op_o = OP_RRN;    mask_o = MASK_ZN;  end
      6'b010001: begin op_o = OP_RLN;    mask_o = MASK_ZN;  end
      6'b001110: begin op_o = OP_SWAP;   mask_o = MASK_NONE; end
      6'b011010: begin
        has_dbit_o = 1'b0;
        to_file_o  = 1'b1;
        op_o       = low_bit ? OP_CLR : OP_SET;
        mask_o     = low_bit ? MASK_Z : MASK_NONE;
      end
      6'b011011: begin
        has_dbit_o = 1'b0;
        to_file_o  = 1'b1;
        op_o       = low_bit ? OP_MOVW : OP_NEG;
        mask_o     = low_bit ? MASK_NONE : MASK_ALL;
      end
      6'b000000: begin
        has_dbit_o = 1'b0;
        to_file_o  = 1'b0;
        if (low_bit) op_o = OP_MUL;
      end
      default: begin
        has_dbit_o = 1'b0;
        to_file_o  = 1'b0;
      end
    endcase
    known_o = (op_o != OP_NONE);
  end
endmodule

// File: rtl/bya_alu.sv
`timescale 1ns/1ps
module bya_alu
  import bya_pkg::*;
(
  input  alu_op_e           op_i,
  input  byte_t             fop_i,
  input  byte_t             wop_i,
  input  logic              cin_i,
  output byte_t             res_o,
  output flags_t            flg_o,
  output logic [PROD_W-1:0] prod_o
);
  byte_t add_a;
  byte_t add_b;
  logic  add_ci;
  logic  add_use;
  add_t  add_r;
  byte_t misc_r;
  logic  rot_c;

  // operand steering onto the single shared adder
  always_comb begin
    add_a   = fop_i;
    add_b   = wop_i;
    add_ci  = 1'b0;
    add_use = 1'b1;
    case (op_i)
      OP_ADD:    ;
      OP_ADDC:   add_ci = cin_i;
      OP_SUBWF:  begin add_b = ~wop_i; add_ci = 1'b1; end
      OP_SUBWFB: begin add_b = ~wop_i; add_ci = cin_i; end
      OP_SUBFWB: begin add_a = wop_i; add_b = ~fop_i; add_ci = cin_i; end
      OP_INC:    add_b = byte_t'(1);
      OP_DEC:    begin add_b = ~byte_t'(1); add_ci = 1'b1; end
      OP_NEG:    begin add_a = '0; add_b = ~fop_i; add_ci = 1'b1; end
      default:   add_use = 1'b0;
    endcase
  end

  assign add_r = add_bytes(add_a, add_b, add_ci);

  // non-arithmetic results and the rotate carry
  always_comb begin
    misc_r = '0;
    rot_c  = cin_i;
    case (op_i)
      OP_AND:  misc_r = fop_i & wop_i;
      OP_IOR:  misc_r = fop_i | wop_i;
      OP_XOR:  misc_r = fop_i ^ wop_i;
      OP_COM:  misc_r = ~fop_i;
      OP_MOV:  misc_r = fop_i;
      OP_RRC:  begin misc_r = {cin_i, fop_i[DATA_W-1:1]}; rot_c = fop_i[0]; end
      OP_RLC:  begin misc_r = {fop_i[DATA_W-2:0], cin_i}; rot_c = fop_i[DATA_W-1]; end
      OP_RRN:  misc_r = {fop_i[0], fop_i[DATA_W-1:1]};
      OP_RLN:  misc_r = {fop_i[DATA_W-2:0], fop_i[DATA_W-1]};
      OP_SWAP: misc_r = swap_halves(fop_i);
      OP_SET:  misc_r = '1;
      OP_CLR:  misc_r = '0;
      OP_MOVW: misc_r = wop_i;
      default: misc_r = '0;
    endcase
  end

  assign res_o = add_use ? add_r.sum : misc_r;

  always_comb begin
    flg_o        = '0;
    flg_o[FL_C]  = add_use ? add_r.c  : rot_c;
    flg_o[FL_DC] = add_use ? add_r.dc : 1'b0;
    flg_o[FL_OV] = add_use ? add_r.ov : 1'b0;
    flg_o[FL_Z]  = (res_o == '0);
    flg_o[FL_N]  = res_o[DATA_W-1];
  end

  assign prod_o = PROD_W'(fop_i) * PROD_W'(wop_i);
endmodule

// File: rtl/byte_reg_alu.sv
`timescale 1ns/1ps
module byte_reg_alu
  import bya_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OPSEL_W-1:0]  ins_hi,
  input  logic [DATA_W-1:0]   fop,
  input  logic [DATA_W-1:0]   wop,
  input  logic [FLAG_W-1:0]   flags_in,
  output logic [DATA_W-1:0]   res,
  output logic                wr_w,
  output logic                wr_f,
  output logic [FLAG_W-1:0]   flags_q,
  output logic [DATA_W-1:0]   prod_hi,
  output logic [DATA_W-1:0]   prod_lo
);
  alu_op_e           dec_op;
  flags_t            dec_mask;
  logic              dec_to_file;
  logic              dec_dbit;
  logic              dec_known;
  flags_t            alu_flg;
  flags_t            flags_nx;
  logic [PROD_W-1:0] alu_prod;
  logic [PROD_W-1:0] prod_q;
  logic              op_is_mul;
  logic              wr_any;

  bya_decode u_dec (
    .sel_i      (ins_hi),
    .op_o       (dec_op),
    .mask_o     (dec_mask),
    .to_file_o  (dec_to_file),
    .has_dbit_o (dec_dbit),
    .known_o    (dec_known)
  );

  bya_alu u_alu (
    .op_i   (dec_op),
    .fop_i  (fop),
    .wop_i  (wop),
    .cin_i  (flags_in[FL_C]),
    .res_o  (res),
    .flg_o  (alu_flg),
    .prod_o (alu_prod)
  );

  // per-flag choice between the fresh value and the pass-through
  for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_flag_merge
    assign flags_nx[gi] = dec_mask[gi] ? alu_flg[gi] : flags_in[gi];
  end

  assign op_is_mul = (dec_op == OP_MUL);
  assign wr_any    = dec_known && !op_is_mul;
  assign wr_f      = wr_any && dec_to_file;
  assign wr_w      = wr_any && !dec_to_file;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      prod_q  <= '0;
    end else begin
      flags_q <= flags_nx;
      if (op_is_mul) prod_q <= alu_prod;
    end
  end

  assign prod_hi = prod_q[PROD_W-1:DATA_W];
  assign prod_lo = prod_q[DATA_W-1:0];

  // R1
  single_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_w, wr_f}));
  // R1
  dest_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_dbit && (wr_w || wr_f)) |-> (wr_f == ins_hi[0]));
  // R2
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op == OP_ADD) |=> (flags_q[FL_C] == ($past(fop) > ~$past(wop))));
  // R3
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op == OP_SUBWF) |=> (flags_q[FL_C] == ($past(fop) >= $past(wop))));
  // R4
  logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op inside {OP_AND, OP_IOR, OP_XOR, OP_COM, OP_MOV}) |=>
      (flags_q[FL_C] == $past(flags_in[FL_C]) && flags_q[FL_DC] == $past(flags_in[FL_DC])
       && flags_q[FL_OV] == $past(flags_in[FL_OV])));
  // R5
  rot_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op == OP_RRC) |=> (flags_q[FL_C] == $past(fop[0])));
  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_op == OP_CLR) |=> (flags_q[FL_Z] && flags_q[FL_N] == $past(flags_in[FL_N])));
  // R7
  mul_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_is_mul |-> !(wr_w || wr_f));
  // R7
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_is_mul |=> $stable({prod_hi, prod_lo}));
  // R8
  unknown_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_known |-> !(wr_w || wr_f));
  // R8
  unknown_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_known |=> (flags_q == $past(flags_in)));
endmodule

// File: tb/tb_byte_reg_alu.sv
`timescale 1ns/1ps
module tb_byte_reg_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] ins_hi = '0;
  logic [7:0] fop = '0;
  logic [7:0] wop = '0;
  logic [4:0] flags_in = '0;
  logic [7:0] res;
  logic       wr_w;
  logic       wr_f;
  logic [4:0] flags_q;
  logic [7:0] prod_hi;
  logic [7:0] prod_lo;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  byte_reg_alu dut (
    .clk(clk), .rst_n(rst_n), .ins_hi(ins_hi), .fop(fop), .wop(wop),
    .flags_in(flags_in), .res(res), .wr_w(wr_w), .wr_f(wr_f),
    .flags_q(flags_q), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  // {req, ins_hi, f, w, flags_in, result, wr_w, wr_f, flags_expected}; flags {N,OV,Z,DC,C}
  localparam int NVEC = 27;
  localparam logic [46:0] VEC [NVEC] = '{
    {4'd2, 7'h12, 8'h7F, 8'h01, 5'h00, 8'h80, 1'b1, 1'b0, 5'h1A}, // R2 add, overflow into sign
    {4'd2, 7'h13, 8'hFF, 8'h01, 5'h00, 8'h00, 1'b0, 1'b1, 5'h07}, // R2 add wraps to zero
    {4'd2, 7'h10, 8'h10, 8'h20, 5'h01, 8'h31, 1'b1, 1'b0, 5'h00}, // R2 add with carry in
    {4'd3, 7'h2F, 8'h05, 8'h03, 5'h00, 8'h02, 1'b0, 1'b1, 5'h03}, // R3 f-w no borrow
    {4'd3, 7'h2E, 8'h03, 8'h05, 5'h00, 8'hFE, 1'b1, 1'b0, 5'h10}, // R3 f-w borrow
    {4'd3, 7'h2C, 8'h10, 8'h01, 5'h00, 8'h0E, 1'b1, 1'b0, 5'h01}, // R3 f-w-borrow
    {4'd3, 7'h2B, 8'h01, 8'h80, 5'h01, 8'h7F, 1'b0, 1'b1, 5'h09}, // R3 w-f-borrow overflow
    {4'd2, 7'h14, 8'h0F, 8'h00, 5'h00, 8'h10, 1'b1, 1'b0, 5'h02}, // R2 increment nibble carry
    {4'd2, 7'h03, 8'h00, 8'h00, 5'h00, 8'hFF, 1'b0, 1'b1, 5'h10}, // R2 decrement below zero
    {4'd2, 7'h02, 8'h80, 8'h00, 5'h00, 8'h7F, 1'b1, 1'b0, 5'h09}, // R2 decrement overflow
    {4'd2, 7'h36, 8'h80, 8'h00, 5'h00, 8'h80, 1'b0, 1'b1, 5'h1A}, // R2 negate most negative
    {4'd2, 7'h36, 8'h00, 8'h00, 5'h00, 8'h00, 1'b0, 1'b1, 5'h07}, // R2 negate zero
    {4'd4, 7'h0A, 8'hF0, 8'h0F, 5'h0B, 8'h00, 1'b1, 1'b0, 5'h0F}, // R4 and
    {4'd4, 7'h09, 8'h80, 8'h01, 5'h04, 8'h81, 1'b0, 1'b1, 5'h10}, // R4 or
    {4'd4, 7'h0C, 8'hAA, 8'hAA, 5'h00, 8'h00, 1'b1, 1'b0, 5'h04}, // R4 xor
    {4'd4, 7'h0F, 8'h0F, 8'h00, 5'h03, 8'hF0, 1'b0, 1'b1, 5'h13}, // R4 complement
    {4'd4, 7'h28, 8'h00, 8'h00, 5'h10, 8'h00, 1'b1, 1'b0, 5'h04}, // R4 move f
    {4'd5, 7'h18, 8'h01, 8'h00, 5'h00, 8'h00, 1'b1, 1'b0, 5'h05}, // R5 rotate right via C
    {4'd5, 7'h1B, 8'h40, 8'h00, 5'h01, 8'h81, 1'b0, 1'b1, 5'h10}, // R5 rotate left via C
    {4'd5, 7'h20, 8'h01, 8'h00, 5'h03, 8'h80, 1'b1, 1'b0, 5'h13}, // R5 rotate right plain
    {4'd5, 7'h23, 8'h80, 8'h00, 5'h00, 8'h01, 1'b0, 1'b1, 5'h00}, // R5 rotate left plain
    {4'd6, 7'h1C, 8'h3C, 8'h00, 5'h15, 8'hC3, 1'b1, 1'b0, 5'h15}, // R6 swap
    {4'd6, 7'h34, 8'h00, 8'h00, 5'h04, 8'hFF, 1'b0, 1'b1, 5'h04}, // R6 set
    {4'd6, 7'h35, 8'h55, 8'h00, 5'h1B, 8'h00, 1'b0, 1'b1, 5'h1F}, // R6 clear
    {4'd6, 7'h37, 8'h00, 8'h5A, 5'h00, 8'h5A, 1'b0, 1'b1, 5'h00}, // R6 move w to f
    {4'd8, 7'h30, 8'h12, 8'h34, 5'h15, 8'h00, 1'b0, 1'b0, 5'h15}, // R8 unlisted code
    {4'd8, 7'h00, 8'h12, 8'h34, 5'h0A, 8'h00, 1'b0, 1'b0, 5'h0A}  // R8 unlisted code
  };

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] s, input logic [7:0] f, input logic [7:0] w, input logic [4:0] st);
    @(negedge clk);
    ins_hi = s; fop = f; wop = w; flags_in = st;
    #1;
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R9 reset holds outputs at zero whatever the inputs ask for
    ins_hi = 7'h01; fop = 8'hFF; wop = 8'hFF; flags_in = 5'h1F;
    repeat (3) @(posedge clk);
    #1;
    chk(flags_q == 5'h00, "R9 flags in reset", 16'(flags_q), 16'h0);
    chk({prod_hi, prod_lo} == 16'h0, "R9 product in reset", {prod_hi, prod_lo}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [46:0] v;
      v = VEC[i];
      drive(v[42:36], v[35:28], v[27:20], v[19:15]);
      chk({wr_w, wr_f} == v[6:5], $sformatf("R1 strobes vec%0d", i), 16'({wr_w, wr_f}), 16'(v[6:5]));
      if (v[6] || v[5])
        chk(res == v[14:7], $sformatf("R%0d result vec%0d", v[46:43], i), 16'(res), 16'(v[14:7]));
      edge_wait();
      chk(flags_q == v[4:0], $sformatf("R%0d flags vec%0d", v[46:43], i), 16'(flags_q), 16'(v[4:0]));
    end

    // R7 multiply with all-ones operands
    drive(7'h01, 8'hFF, 8'hFF, 5'h0A);
    chk({wr_w, wr_f} == 2'b00, "R7 multiply strobes", 16'({wr_w, wr_f}), 16'h0);
    edge_wait();
    chk({prod_hi, prod_lo} == 16'hFE01, "R7 product", {prod_hi, prod_lo}, 16'hFE01);
    chk(flags_q == 5'h0A, "R7 flags kept", 16'(flags_q), 16'h0A);

    // R7 product holds across another operation (xor AA^AA leaves flags 04)
    drive(7'h0C, 8'hAA, 8'hAA, 5'h00);
    edge_wait();
    chk({prod_hi, prod_lo} == 16'hFE01, "R7 product held", {prod_hi, prod_lo}, 16'hFE01);

    // R10 result is immediate, flags wait for the edge
    drive(7'h12, 8'h7F, 8'h01, 5'h00);
    chk(res == 8'h80, "R10 result same cycle", 16'(res), 16'h80);
    chk(flags_q == 5'h04, "R10 flags before edge", 16'(flags_q), 16'h04);
    edge_wait();
    chk(flags_q == 5'h1A, "R10 flags after edge", 16'(flags_q), 16'h1A);

    // R7 second multiply, product before and after the edge
    drive(7'h01, 8'h20, 8'h10, 5'h00);
    chk({prod_hi, prod_lo} == 16'hFE01, "R10 product before edge", {prod_hi, prod_lo}, 16'hFE01);
    edge_wait();
    chk({prod_hi, prod_lo} == 16'h0200, "R7 product small", {prod_hi, prod_lo}, 16'h0200);

    // R1 destination bit flips only the strobe
    drive(7'h0B, 8'hF0, 8'h3C, 5'h00);
    chk(wr_f && !wr_w && res == 8'h30, "R1 and to file", 16'({wr_w, wr_f, res}), 16'({2'b01, 8'h30}));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule